// File: doc/BRIEF.md
# Clause 45 MDIO Management Controller

This block lets software reach registers inside external PHYs over a two-wire management link, using the indirect Clause 45 access method. Software first writes the target register address into an address register. It then writes a command into the management register. The command holds the port address, the device address, a 3-bit opcode and, for a write, 16 bits of data.

A valid command starts a transaction that sends two frames back to back. The first is an address frame that carries the stored register address. The second is a data frame that either writes the supplied data or reads 16 bits back from the PHY. Software polls the busy flag in the management register until it clears. After a read it takes the result from the low half of that register, which is qualified by a read-valid flag.

The management clock comes from a parameterised divider of the system clock. The data line is driven through a separate output-enable, so that a pad tristate can release it while the PHY answers.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset, the management register reads as all zeros. The management clock is low and the data-line enable is low.
- R2: A write to offset 0x8 stores bits [15:0] as the target register address. Reading offset 0x8 returns that value with bits [31:16] zero.
- R3: A write to offset 0x0 while idle starts a transaction only when the opcode field in bits [28:26] is 5 (write) or 7 (read). Any other opcode leaves the busy flag, read-valid flag and read data unchanged.
- R4: In the command word, the port address is bits [20:16], the device address is bits [25:21] and the write data is bits [15:0]. The opcode is bits [28:26], as stated in R3.
- R5: Each transaction first sends an address frame, most significant bit first. It consists of 32 ones, start 00, opcode 00, the 5-bit port address, the 5-bit device address, turnaround 10 and the 16-bit register address from offset 0x8 as held at command time.
- R6: The address frame is followed at once by a data frame with the same preamble, start, port and device fields. Its opcode is 01 with turnaround 10 and the 16 write data bits for a write, and 11 for a read.
- R7: In a read data frame, the data-line enable is low for the two turnaround bits and the 16 data bits. The PHY's data is sampled on the rising management-clock edges, most significant bit first.
- R8: The busy flag (bit 30 of offset 0x0) is set from the cycle after the command is accepted. It stays set for exactly 128 bit periods (256 × CLK_DIV system cycles).
- R9: The read-valid flag (bit 29) clears when a new command is accepted. It sets, with the sampled word in bits [15:0], when a read finishes. A write finishes with the flag still clear.
- R10: A command written to offset 0x0 while busy is ignored. The running transaction keeps its timing and content.
- R11: Each bit period is CLK_DIV cycles with the management clock low, then CLK_DIV cycles with it high. The data line and its enable change only where the clock falls. The clock rests low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | 4 | Register byte offset for reads and writes |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr, combinational |
| mdc | output | 1 | Management clock to the PHYs |
| mdioOut | output | 1 | Data line value when driven |
| mdioOe | output | 1 | Data line drive enable |
| mdioIn | input | 1 | Data line value seen at the pad |

## Verification
The hardest case to reach is a command arriving while a transaction is already running. It has to be shown to have no effect at all: not on the bit stream on the wire, not on the busy time, and not on the read-valid flag. The stimulus issues a read command and an address-register update partway through a write transaction. The reference model predicts every cycle of the wire and the flags, so any disturbance shows up as a mismatch. The run then checks that the write ends without read-valid set. A PHY model also answers reads, both right after a write and back to back with an invalid opcode in between. This covers the clearing and setting of read-valid and the timing of the release and sampling points.

// File: rtl/mdio_c45_pkg.sv
`timescale 1ns/1ps
package mdio_c45_pkg;
  localparam int REG_AW    = 4;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int TA_POS    = PRE_LEN + 14;  // first turnaround bit in a frame
  localparam int DATA_POS  = PRE_LEN + 16;  // first data bit in a frame

  localparam logic [REG_AW-1:0] MGMT_OFS = 4'h0;
  localparam logic [REG_AW-1:0] ADDR_OFS = 4'h8;

  localparam int PRT_LSB  = 16;
  localparam int DEV_LSB  = 21;
  localparam int OP_LSB   = 26;
  localparam int RV_BIT   = 29;
  localparam int BUSY_BIT = 30;

  localparam logic [2:0] OPC_WRITE = 3'd5;
  localparam logic [2:0] OPC_READ  = 3'd7;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} seqState_t;

  typedef struct packed {
    logic launch;      // accept a command, load address frame
    logic nextFrame;   // address frame done, load data frame
    logic shiftBit;    // advance to the next bit of the frame
    logic sampleBit;   // capture the data line (read data bits)
    logic finish;      // transaction done
    logic busRelease;  // data line released to the PHY
  } ctrlStrobes_t;
endpackage

// File: rtl/mdio_c45_seq.sv
`timescale 1ns/1ps
module mdio_c45_seq
  import mdio_c45_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmdReq,
  input  logic         isRead,
  output ctrlStrobes_t strb,
  output logic         mdc,
  output logic         busy
);
  localparam int PHASE_N = 2 * CLK_DIV;
  localparam int PHASE_W = (PHASE_N > 1) ? $clog2(PHASE_N) : 1;
  localparam int BIT_W   = $clog2(FRAME_LEN);

  seqState_t          state;
  logic [PHASE_W-1:0] phase;
  logic [BIT_W-1:0]   bitIdx;
  logic               endPhase, risePhase, lastBit;

  assign endPhase  = (phase == PHASE_W'(PHASE_N - 1));
  assign risePhase = (phase == PHASE_W'(CLK_DIV - 1));
  assign lastBit   = (bitIdx == BIT_W'(FRAME_LEN - 1));
  assign busy      = (state != ST_IDLE);

  always_comb begin
    strb            = '0;
    strb.launch     = (state == ST_IDLE) && cmdReq;
    strb.shiftBit   = busy && endPhase && !lastBit;
    strb.nextFrame  = (state == ST_ADDR) && endPhase && lastBit;
    strb.finish     = (state == ST_DATA) && endPhase && lastBit;
    strb.sampleBit  = (state == ST_DATA) && isRead && risePhase &&
                      (bitIdx >= BIT_W'(DATA_POS));
    strb.busRelease = (state == ST_DATA) && isRead &&
                      (bitIdx >= BIT_W'(TA_POS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      phase  <= '0;
      bitIdx <= '0;
      mdc    <= 1'b0;
    end else if (strb.launch) begin
      state  <= ST_ADDR;
      phase  <= '0;
      bitIdx <= '0;
      mdc    <= 1'b0;
    end else if (busy) begin
      if (endPhase) begin
        phase  <= '0;
        mdc    <= 1'b0;
        bitIdx <= lastBit ? '0 : bitIdx + BIT_W'(1);
        if (strb.nextFrame)   state <= ST_DATA;
        else if (strb.finish) state <= ST_IDLE;
      end else begin
        phase <= phase + PHASE_W'(1);
        if (risePhase) mdc <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_c45_regs.sv
`timescale 1ns/1ps
module mdio_c45_regs
  import mdio_c45_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  ctrlStrobes_t      strb,
  input  logic              busy,
  input  logic              mdioIn,
  output logic              cmdReq,
  output logic              isRead,
  output logic              readValid,
  output logic              mdioOut,
  output logic              mdioOe
);
  logic [15:0]          addrReg, wrDataReg, rdShift, rdData;
  logic [4:0]           prtReg, devReg;
  logic [FRAME_LEN-1:0] frameSh;
  logic [2:0]           opField;
  logic                 unusedBits;

  assign opField    = regWrData[OP_LSB +: 3];
  assign unusedBits = ^regWrData[31:29];
  assign cmdReq     = regWrEn && (regAddr == MGMT_OFS) &&
                      ((opField == OPC_WRITE) || (opField == OPC_READ));
  assign mdioOut    = frameSh[FRAME_LEN-1];
  assign mdioOe     = busy && !strb.busRelease;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrReg   <= '0;
      wrDataReg <= '0;
      prtReg    <= '0;
      devReg    <= '0;
      isRead    <= 1'b0;
      frameSh   <= '1;
      rdShift   <= '0;
      rdData    <= '0;
      readValid <= 1'b0;
    end else begin
      if (regWrEn && (regAddr == ADDR_OFS)) addrReg <= regWrData[15:0];
      if (strb.launch) begin
        prtReg    <= regWrData[PRT_LSB +: 5];
        devReg    <= regWrData[DEV_LSB +: 5];
        wrDataReg <= regWrData[15:0];
        isRead    <= (opField == OPC_READ);
        readValid <= 1'b0;
        frameSh   <= {{PRE_LEN{1'b1}}, 2'b00, 2'b00, regWrData[PRT_LSB +: 5],
                      regWrData[DEV_LSB +: 5], 2'b10, addrReg};
      end else if (strb.nextFrame) begin
        frameSh <= {{PRE_LEN{1'b1}}, 2'b00, isRead ? 2'b11 : 2'b01, prtReg,
                    devReg, 2'b10, isRead ? 16'hFFFF : wrDataReg};
      end else if (strb.shiftBit) begin
        frameSh <= {frameSh[FRAME_LEN-2:0], 1'b1};
      end
      if (strb.sampleBit) rdShift <= {rdShift[14:0], mdioIn};
      if (strb.finish && isRead) begin
        rdData    <= rdShift;
        readValid <= 1'b1;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == MGMT_OFS) begin
      regRdData[15:0]     = rdData;
      regRdData[RV_BIT]   = readValid;
      regRdData[BUSY_BIT] = busy;
    end else if (regAddr == ADDR_OFS) begin
      regRdData[15:0] = addrReg;
    end
  end
endmodule

// File: rtl/mdio_c45_master.sv
`timescale 1ns/1ps
module mdio_c45_master
  import mdio_c45_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        regWrEn,
  input  logic [3:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  ctrlStrobes_t strb;
  logic busyFlag, readValid, cmdReq, isRead;

  mdio_c45_seq #(.CLK_DIV(CLK_DIV)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmdReq(cmdReq), .isRead(isRead),
    .strb(strb), .mdc(mdc), .busy(busyFlag)
  );

  mdio_c45_regs u_regs (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strb(strb),
    .busy(busyFlag), .mdioIn(mdioIn), .cmdReq(cmdReq), .isRead(isRead),
    .readValid(readValid), .mdioOut(mdioOut), .mdioOe(mdioOe)
  );
endmodule

// File: rtl/mdio_c45_checker.sv
`timescale 1ns/1ps
module mdio_c45_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       regWrEn,
  input logic [3:0] regAddr,
  input logic       busyFlag,
  input logic       readValid,
  input logic       mdc,
  input logic       mdioOut,
  input logic       mdioOe
);
  assert_start_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busyFlag) |-> ($past(regWrEn) && ($past(regAddr) == 4'h0)));

  assert_valid_clears_on_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busyFlag) |-> !readValid);

  assert_valid_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(readValid) |-> $fell(busyFlag));

  assert_drive_only_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mdioOe |-> busyFlag);

  assert_clock_rests_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busyFlag |-> !mdc);

  assert_line_steady_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdioOut) && $stable(mdioOe)));
endmodule

bind mdio_c45_master mdio_c45_checker u_chk (
  .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
  .busyFlag(busyFlag), .readValid(readValid), .mdc(mdc),
  .mdioOut(mdioOut), .mdioOe(mdioOe)
);

// File: tb/mdio_c45_master_test.sv
`timescale 1ns/1ps
module mdio_c45_master_test;
  localparam int D   = 2;
  localparam int TXN = 128 * 2 * D;

  logic clk = 1'b0, rst_n = 1'b0, regWrEn = 1'b0, mdioIn = 1'b1;
  logic [3:0]  regAddr = 4'h0;
  logic [31:0] regWrData = '0, regRdData;
  logic mdc, mdioOut, mdioOe;

  int tests = 0, fails = 0, cyc = 0;
  bit chkOn = 1'b0;

  // reference model state
  int           mT = -1;
  bit           mRd = 1'b0, mRv = 1'b0;
  logic [15:0]  mData = '0, mAddr = '0, mPhy = '0;
  logic [127:0] mFrame = '1;

  mdio_c45_master #(.CLK_DIV(D)) uut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always #4 clk = ~clk;

  task automatic checkEq(string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // behavioural model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mT = -1; mRv = 0; mData = '0; mAddr = '0;
    end else begin
      if (mT >= 0) begin
        if (mT == TXN - 1) begin
          mT = -1;
          if (mRd) begin mRv = 1; mData = mPhy; end
        end else mT++;
      end else if (regWrEn && regAddr == 4'h0 &&
                   (regWrData[28:26] == 3'd5 || regWrData[28:26] == 3'd7)) begin
        // R4 field positions, R5 address frame, R6 data frame
        mT  = 0;
        mRd = (regWrData[28:26] == 3'd7);
        mRv = 0;
        mFrame = {32'hFFFF_FFFF, 2'b00, 2'b00, regWrData[20:16], regWrData[25:21], 2'b10, mAddr,
                  32'hFFFF_FFFF, 2'b00, mRd ? 2'b11 : 2'b01, regWrData[20:16],
                  regWrData[25:21], 2'b10, regWrData[15:0]};
      end
      if (regWrEn && regAddr == 4'h8) mAddr = regWrData[15:0];
    end
  end

  // PHY model and per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    int bitG;
    bitG = (mT >= 0) ? mT / (2 * D) : 0;
    if (mT >= 0 && mRd && bitG >= 112) mdioIn = mPhy[15 - (bitG - 112)];
    else mdioIn = 1'b1;
    #1;
    if (rst_n && chkOn) begin
      if (mT < 0) begin
        checkEq("R11", "idle mdc", {31'd0, mdc}, 32'd0);
        checkEq("R7", "idle oe", {31'd0, mdioOe}, 32'd0);
      end else begin
        checkEq("R11", "mdc phase", {31'd0, mdc}, {31'd0, ((mT % (2 * D)) >= D)});
        checkEq("R7", "oe", {31'd0, mdioOe}, {31'd0, !(mRd && bitG >= 64 + 46)});
        if (mdioOe) checkEq("R5/R6", "mdio bit", {31'd0, mdioOut}, {31'd0, mFrame[127 - bitG]});
      end
      if (regAddr == 4'h0)
        checkEq("R8/R9", "mgmt readback", regRdData,
                {1'b0, (mT >= 0), mRv, 13'd0, mData});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R8 watchdog: actual %0d cycles expected fewer than 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic writeReg(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 4'h0;
  endtask

  task automatic readReg(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #2 d = regRdData;
    @(negedge clk);
    regAddr = 4'h0;
  endtask

  task automatic sendCmd(logic [2:0] op, logic [4:0] prt, logic [4:0] dev, logic [15:0] d);
    writeReg(4'h0, {3'b000, op, dev, prt, d});
  endtask

  task automatic waitIdle();
    while (mT >= 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    #2;
    checkEq("R1", "reset readback", regRdData, 32'd0);
    checkEq("R1", "reset mdc", {31'd0, mdc}, 32'd0);
    checkEq("R1", "reset oe", {31'd0, mdioOe}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    chkOn = 1'b1;

    writeReg(4'h8, 32'hABCD_1234);
    readReg(4'h8, rv);
    checkEq("R2", "address readback", rv, 32'h0000_1234);

    // write transaction with a read command and address update mid-flight (R10)
    sendCmd(3'd5, 5'h03, 5'h1E, 16'hBEEF);
    repeat (40) @(negedge clk);
    sendCmd(3'd7, 5'h1F, 5'h1F, 16'h0000);
    writeReg(4'h8, 32'h0000_5555);
    waitIdle();
    readReg(4'h0, rv);
    checkEq("R10", "ignored read left no result", rv, 32'h0000_0000);

    // read transaction
    writeReg(4'h8, 32'h0000_8001);
    mPhy = 16'hC35A;
    sendCmd(3'd7, 5'h11, 5'h01, 16'h0000);
    waitIdle();
    readReg(4'h0, rv);
    checkEq("R7", "read result", rv, 32'h2000_C35A);

    // invalid opcodes are ignored
    sendCmd(3'd6, 5'h02, 5'h02, 16'h1111);
    readReg(4'h0, rv);
    checkEq("R3", "opcode 6 ignored", rv, 32'h2000_C35A);
    sendCmd(3'd0, 5'h02, 5'h02, 16'h2222);
    readReg(4'h0, rv);
    checkEq("R3", "opcode 0 ignored", rv, 32'h2000_C35A);

    // back-to-back read, boundary addresses; valid clears at start
    mPhy = 16'h0F0F;
    sendCmd(3'd7, 5'h1F, 5'h00, 16'h0000);
    readReg(4'h0, rv);
    checkEq("R9", "valid cleared at start", {31'd0, rv[29]}, 32'd0);
    checkEq("R8", "busy after start", {31'd0, rv[30]}, 32'd1);
    waitIdle();
    readReg(4'h0, rv);
    checkEq("R9", "second read result", rv, 32'h2000_0F0F);

    // write after read clears valid and ends with it clear
    sendCmd(3'd5, 5'h00, 5'h1F, 16'h0001);
    waitIdle();
    readReg(4'h0, rv);
    checkEq("R9", "write completion", rv, 32'h0000_0F0F);

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule